// File: doc/BRIEF.md
# Local Bus Cycle Controller with Hold

This block sequences the external bus transactions of a 16-bit processor that has a 24-bit physical address. The core offers one request at a time. A request carries a cycle kind, an address, two byte enables, write data and a lock flag. Once the controller accepts a request, it spends exactly one send-status clock. In that clock it presents the active-low status pair, the memory/IO select, the code/interrupt-acknowledge select, the byte-high enable and the address. It then enters command clocks and stays in them until the active-low ready input is sampled low. On that edge it captures the read data and returns it to the core with a one-clock response strobe.

A second bus master can ask for the bus with a hold request. That input passes through a synchroniser. The grant happens only between cycles and never while a locked sequence is open. To grant, the controller first spends one clock with every driver group released. Only after that does it raise hold acknowledge. Each bus group is modelled as a value signal plus an output enable, so the float behaviour of every group can be observed. When the synchronised request goes away, hold acknowledge drops and the drivers resume in the same clock.

Top module: `busc_top`

## Requirements
- R1: After reset the block is idle. In that state `busS1N` and `busS0N` are both 1, `busLockN` is 1, `holdAck` is 0, `busDataOe` is 0, `rspValid` is 0, `busAddrOe` is 1 and `reqReady` is 1.
- R2: An accepted request produces exactly one send-status clock. In that clock {`busCodeInta`,`busMemIo`,`busS1N`,`busS0N`} carries the kind's code:
  - `reqKind` 0 (interrupt acknowledge) gives 0000.
  - `reqKind` 1 (halt) and 2 (shutdown) give 0100.
  - `reqKind` 3 (memory read) gives 0101.
  - `reqKind` 4 (memory write) gives 0110.
  - `reqKind` 5 (I/O read) gives 1001.
  - `reqKind` 6 (I/O write) gives 1010.
  - `reqKind` 7 (instruction fetch) gives 1101.
  
  In every other clock both status lines are 1.
- R3: Command clocks repeat for as long as `busReadyN` is 1 at the rising edge. `rspValid` is 1 for the single clock after the edge at which `busReadyN` is 0. For the read kinds (0, 3, 5, 7), `rspData` then equals `busDataIn` as sampled at that edge.
- R4: Byte lanes follow `reqByteEn`, where bit 1 is the upper lane:
  - 11 drives `busBheN`=0 and address bit 0 = 0.
  - 10 drives `busBheN`=0 and bit 0 = 1.
  - 01 or 00 drives `busBheN`=1 and bit 0 = 0.
  
  The pair `busBheN`=1 with bit 0 = 1 never appears.
- R5: Address bit 1 is forced to 1 for halt and to 0 for shutdown.
- R6: For I/O kinds, address bits 23..16 are driven as 0. For all other kinds, address bits 23..2 follow `reqAddr`.
- R7: In the command clocks of a write kind, `busDataOe` is 1 and `busDataOut` equals the request's write data. In every read-like cycle, `busDataOe` stays 0.
- R8: Hold is granted only between bus cycles. The grant starts with one clock in which `busAddrOe`, `busStatusOe`, `busCmdOe` and `busDataOe` are all 0 and `holdAck` is still 0. `holdAck` rises in the following clock.
- R9: While floated, `busS1N`, `busS0N` and `busLockN` read 1. `busMemIo`, `busCodeInta` and `busDataOut` keep their last driven levels. `holdAck` itself is always driven.
- R10: While `holdAck` is 1, `busReadyN` has no effect: no response is produced. `reqReady` is 0 during hold, so no request is accepted.
- R11: Once the synchronised hold request is inactive, `holdAck` returns to 0. All driver enables return to 1 in that same clock.
- R12: A request with `reqLock`=1 drives `busLockN` low from its send-status clock. `busLockN` stays low up to the completion of the next cycle that has `reqLock`=0. While it is low, hold is not granted and requests are still accepted.
- R13: `reqReady` is 1 only when the controller is idle and no hold grant is about to start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core offers a request |
| reqReady | output | 1 | Request accepted at this edge when high with reqValid |
| reqKind | input | 3 | Cycle kind, encoding in R2 |
| reqAddr | input | 24 | Request address |
| reqByteEn | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| reqWdata | input | 16 | Write data |
| reqLock | input | 1 | Request belongs to a locked sequence |
| rspValid | output | 1 | One-clock completion strobe |
| rspData | output | 16 | Captured read data |
| busReadyN | input | 1 | Active-low ready, sampled in command clocks |
| busDataIn | input | 16 | Data bus input |
| busDataOut | output | 16 | Data bus drive value |
| busDataOe | output | 1 | Data bus output enable |
| busAddr | output | 24 | Address drive value |
| busAddrOe | output | 1 | Enable for address and byte-high enable |
| busBheN | output | 1 | Active-low byte-high enable |
| busStatusOe | output | 1 | Enable for status and lock |
| busS1N | output | 1 | Status line 1, active low |
| busS0N | output | 1 | Status line 0, active low |
| busLockN | output | 1 | Active-low bus lock |
| busCmdOe | output | 1 | Enable for memory/IO and code/INTA selects |
| busMemIo | output | 1 | Memory (1) / I/O (0) select |
| busCodeInta | output | 1 | Code (1) / interrupt acknowledge (0) select |
| holdReq | input | 1 | Asynchronous hold request from another master |
| holdAck | output | 1 | Hold acknowledge, never floated |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 16-bit data bus, an I/O space of 16 address bits and a two-flop hold synchroniser.

With these values, the masking of bits 23..16 on I/O cycles is visible, and the forced address bits 1 and 0 can be compared against arbitrary request addresses. The two-clock synchroniser delay also allows a hold request raised in the same clock as a request to land inside a running cycle, which exercises the cycle-boundary rule. Wait-state counts from zero to three cover both the shortest cycle and extended command phases.

// File: rtl/busc_pkg.sv
package busc_pkg;

  typedef enum logic [2:0] {
    KIND_INTA     = 3'd0,
    KIND_HALT     = 3'd1,
    KIND_SHUTDOWN = 3'd2,
    KIND_MEM_RD   = 3'd3,
    KIND_MEM_WR   = 3'd4,
    KIND_IO_RD    = 3'd5,
    KIND_IO_WR    = 3'd6,
    KIND_FETCH    = 3'd7
  } cycleKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;       // latch the accepted request
    logic captureRd;     // ready seen: capture data, complete
    logic statusActive;  // send-status clock
    logic drvBus;        // address/status/select groups driven
    logic drvData;       // data bus driven
  } busStrobe_t;

  // {code/inta, mem/io, s1, s0} as pin levels
  function automatic logic [3:0] kindCode(cycleKind_t k);
    case (k)
      KIND_INTA:     return 4'b0000;
      KIND_HALT:     return 4'b0100;
      KIND_SHUTDOWN: return 4'b0100;
      KIND_MEM_RD:   return 4'b0101;
      KIND_MEM_WR:   return 4'b0110;
      KIND_IO_RD:    return 4'b1001;
      KIND_IO_WR:    return 4'b1010;
      KIND_FETCH:    return 4'b1101;
      default:       return 4'b0011;
    endcase
  endfunction

  function automatic logic isWriteKind(cycleKind_t k);
    return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
  endfunction

  function automatic logic isIoKind(cycleKind_t k);
    return (k == KIND_IO_RD) || (k == KIND_IO_WR);
  endfunction

endpackage

// File: rtl/busc_ctrl.sv
module busc_ctrl
  import busc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLock,
  input  cycleKind_t reqKind,
  input  logic       busReadyN,
  input  logic       holdReq,
  output logic       reqReady,
  output logic       holdAck,
  output logic       busLockN,
  output busStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_CMD   = 3'd2,
    ST_FLOAT = 3'd3,
    ST_HOLD  = 3'd4
  } busState_t;

  busState_t state, nextState;
  logic [SYNC_STAGES-1:0] holdPipe;
  logic holdSync;
  logic lockActive;
  logic curLock;
  logic curWrite;
  logic grantOk;
  logic floated;

  // hold request synchroniser
  generate
    if (SYNC_STAGES > 1) begin : g_multiSync
      always_ff @(posedge clk) begin
        if (!rstN) holdPipe <= '0;
        else       holdPipe <= {holdPipe[SYNC_STAGES-2:0], holdReq};
      end
    end else begin : g_singleSync
      always_ff @(posedge clk) begin
        if (!rstN) holdPipe <= '0;
        else       holdPipe <= holdReq;
      end
    end
  endgenerate

  assign holdSync = holdPipe[SYNC_STAGES-1];
  assign grantOk  = holdSync && !lockActive;
  assign floated  = (state == ST_FLOAT) || (state == ST_HOLD);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (grantOk)       nextState = ST_FLOAT;
        else if (reqValid) nextState = ST_SEND;
      end
      ST_SEND:  nextState = ST_CMD;
      ST_CMD:   if (!busReadyN) nextState = ST_IDLE;
      ST_FLOAT: nextState = ST_HOLD;
      ST_HOLD:  if (!holdSync) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadReq      = (state == ST_IDLE) && !grantOk && reqValid;
    strobe.captureRd    = (state == ST_CMD) && !busReadyN;
    strobe.statusActive = (state == ST_SEND);
    strobe.drvBus       = !floated;
    strobe.drvData      = (state == ST_CMD) && curWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lockActive <= 1'b0;
      curLock    <= 1'b0;
      curWrite   <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadReq) begin
        curLock  <= reqLock;
        curWrite <= isWriteKind(reqKind);
        if (reqLock) lockActive <= 1'b1;
      end
      if (strobe.captureRd && !curLock) lockActive <= 1'b0;
    end
  end

  assign reqReady = (state == ST_IDLE) && !grantOk;
  assign holdAck  = (state == ST_HOLD);
  assign busLockN = !(lockActive && !floated);

endmodule

// File: rtl/busc_dpath.sv
module busc_dpath
  import busc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int IO_ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  cycleKind_t        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic              busBheN,
  output logic              busStatusOe,
  output logic              busS1N,
  output logic              busS0N,
  output logic              busCmdOe,
  output logic              busMemIo,
  output logic              busCodeInta,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe
);

  logic [ADDR_W-1:0] addrReg, nextAddr;
  logic              bheReg;
  logic [3:0]        codeReg;
  logic [DATA_W-1:0] dataReg;
  logic              reqIo;
  logic              upperOnly;

  assign reqIo     = isIoKind(reqKind);
  assign upperOnly = (reqByteEn == 2'b10);

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      nextAddr[b] = (reqIo && (b >= IO_ADDR_W)) ? 1'b0 : reqAddr[b];
    end
    if (reqKind == KIND_HALT)     nextAddr[1] = 1'b1;
    if (reqKind == KIND_SHUTDOWN) nextAddr[1] = 1'b0;
    nextAddr[0] = upperOnly;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      bheReg   <= 1'b1;
      codeReg  <= 4'b0011;
      dataReg  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrReg <= nextAddr;
        bheReg  <= ~reqByteEn[1];
        codeReg <= kindCode(reqKind);
        dataReg <= reqWdata;
      end
      rspValid <= strobe.captureRd;
      if (strobe.captureRd) rspData <= busDataIn;
    end
  end

  assign busAddr     = addrReg;
  assign busBheN     = bheReg;
  assign busAddrOe   = strobe.drvBus;
  assign busStatusOe = strobe.drvBus;
  assign busCmdOe    = strobe.drvBus;
  assign busS1N      = strobe.statusActive ? codeReg[1] : 1'b1;
  assign busS0N      = strobe.statusActive ? codeReg[0] : 1'b1;
  assign busMemIo    = codeReg[2];
  assign busCodeInta = codeReg[3];
  assign busDataOut  = dataReg;
  assign busDataOe   = strobe.drvData;

endmodule

// File: rtl/busc_top.sv
module busc_top
  import busc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int IO_ADDR_W   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqLock,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              busReadyN,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAddrOe,
  output logic              busBheN,
  output logic              busStatusOe,
  output logic              busS1N,
  output logic              busS0N,
  output logic              busLockN,
  output logic              busCmdOe,
  output logic              busMemIo,
  output logic              busCodeInta,
  input  logic              holdReq,
  output logic              holdAck
);

  busStrobe_t strobe;
  cycleKind_t kind;

  assign kind = cycleKind_t'(reqKind);

  busc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLock  (reqLock),
    .reqKind  (kind),
    .busReadyN(busReadyN),
    .holdReq  (holdReq),
    .reqReady (reqReady),
    .holdAck  (holdAck),
    .busLockN (busLockN),
    .strobe   (strobe)
  );

  busc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_ADDR_W(IO_ADDR_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqKind    (kind),
    .reqAddr    (reqAddr),
    .reqByteEn  (reqByteEn),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .busAddr    (busAddr),
    .busAddrOe  (busAddrOe),
    .busBheN    (busBheN),
    .busStatusOe(busStatusOe),
    .busS1N     (busS1N),
    .busS0N     (busS0N),
    .busCmdOe   (busCmdOe),
    .busMemIo   (busMemIo),
    .busCodeInta(busCodeInta),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe)
  );

endmodule

// File: rtl/busc_chk.sv
module busc_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspValid,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAddrOe,
  input logic              busBheN,
  input logic              busStatusOe,
  input logic              busS1N,
  input logic              busS0N,
  input logic              busLockN,
  input logic              busCmdOe,
  input logic              busMemIo,
  input logic              busCodeInta,
  input logic              holdAck
);

  logic statusOn;
  assign statusOn = !(busS1N && busS0N);

  // R2
  status_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOn |=> (busS1N && busS0N));

  // R4
  lane_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOn |-> !(busBheN && busAddr[0]));

  // R6
  io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOn && busCodeInta && !busMemIo) |-> (busAddr[ADDR_W-1:16] == '0));

  // R7
  read_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOn && !busS1N) |=> !busDataOe);

  // R8
  float_before_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(!busAddrOe && !busStatusOe && !busCmdOe && !busDataOe));

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!busAddrOe && !busStatusOe && !busCmdOe && !busDataOe &&
                 busS1N && busS0N && busLockN));

  // R9
  hold_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> ($stable(busMemIo) && $stable(busCodeInta) && $stable(busDataOut)));

  // R10
  hold_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> !rspValid);

  // R12
  lock_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(busLockN, 2));

endmodule

bind busc_top busc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/busc_tb.sv
module busc_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqKind = 3'd0;
  logic [23:0] reqAddr = '0;
  logic [1:0]  reqByteEn = 2'b11;
  logic [15:0] reqWdata = '0;
  logic        reqLock = 1'b0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        busReadyN = 1'b1;
  logic [15:0] busDataIn = '0;
  logic [15:0] busDataOut;
  logic        busDataOe;
  logic [23:0] busAddr;
  logic        busAddrOe, busBheN, busStatusOe, busS1N, busS0N, busLockN;
  logic        busCmdOe, busMemIo, busCodeInta;
  logic        holdReq = 1'b0;
  logic        holdAck;

  int checks = 0;
  int failures = 0;
  logic [15:0] expQ[$];
  bit          chkQ[$];

  always #5 clk = ~clk;

  busc_top dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expCode(input logic [2:0] k);
    case (k)
      3'd0: return 4'b0000;
      3'd1, 3'd2: return 4'b0100;
      3'd3: return 4'b0101;
      3'd4: return 4'b0110;
      3'd5: return 4'b1001;
      3'd6: return 4'b1010;
      default: return 4'b1101;
    endcase
  endfunction

  function automatic logic [23:0] expAddr(input logic [2:0] k, input logic [23:0] a,
                                          input logic [1:0] be);
    logic [23:0] r;
    r = a;
    if (k == 3'd5 || k == 3'd6) r[23:16] = 8'h00;
    if (k == 3'd1) r[1] = 1'b1;
    if (k == 3'd2) r[1] = 1'b0;
    r[0] = (be == 2'b10);
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        chk("R3 unexpected response", 1, 0);
      end else begin
        logic [15:0] e;
        bit c;
        e = expQ.pop_front();
        c = chkQ.pop_front();
        if (c) chk("R3 read data", rspData, e);
      end
    end
  end

  task automatic doCycle(input logic [2:0] kind, input logic [23:0] addr, input logic [1:0] be,
                         input logic [15:0] wd, input logic lk, input int waits,
                         input logic [15:0] rd, input logic raiseHold);
    logic wr;
    wr = (kind == 3'd4 || kind == 3'd6);
    @(negedge clk);
    chk("R13 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqByteEn = be;
    reqWdata = wd; reqLock = lk;
    if (raiseHold) holdReq = 1'b1;
    expQ.push_back(rd);
    chkQ.push_back(kind == 3'd0 || kind == 3'd3 || kind == 3'd5 || kind == 3'd7);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 status code", {busCodeInta, busMemIo, busS1N, busS0N}, expCode(kind));
    chk("R5/R6 address", busAddr, expAddr(kind, addr, be));
    chk("R4 lanes", {busBheN, busAddr[0]}, {~be[1], be == 2'b10});
    if (lk) chk("R12 lock low", busLockN, 0);
    for (int i = 0; i <= waits; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 status idle in command", {busS1N, busS0N}, 2'b11);
      chk("R7 data enable", busDataOe, wr);
      if (wr) chk("R7 write data", busDataOut, wd);
      chk("R3 no early response", rspValid, 0);
      chk("R8 no grant inside cycle", holdAck, 0);
      busReadyN = (i == waits) ? 1'b0 : 1'b1;
      busDataIn = (i == waits) ? rd : ~rd;
    end
    @(posedge clk);
    @(negedge clk);
    busReadyN = 1'b1;
    chk("R3 response strobe", rspValid, 1);
  endtask

  task automatic waitGrant();
    int got;
    logic lastMio, lastCod;
    logic [15:0] lastData;
    lastMio = busMemIo; lastCod = busCodeInta; lastData = busDataOut;
    holdReq = 1'b1;
    got = 0;
    for (int i = 0; i < 12 && got == 0; i++) begin
      @(negedge clk);
      if (!busAddrOe) got = 1;
    end
    chk("R8 float seen", busAddrOe, 0);
    chk("R8 ack after float", holdAck, 0);
    chk("R8 groups floated", {busStatusOe, busCmdOe, busDataOe}, 3'b000);
    chk("R9 float-one values", {busS1N, busS0N, busLockN}, 3'b111);
    chk("R9 held levels", {busMemIo, busCodeInta, busDataOut}, {lastMio, lastCod, lastData});
    @(negedge clk);
    chk("R8 ack raised", holdAck, 1);
  endtask

  task automatic releaseHold();
    int got;
    holdReq = 1'b0;
    got = 0;
    for (int i = 0; i < 12 && got == 0; i++) begin
      @(negedge clk);
      if (!holdAck) got = 1;
    end
    chk("R11 ack dropped", holdAck, 0);
    chk("R11 drivers back", {busAddrOe, busStatusOe, busCmdOe}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status idle", {busS1N, busS0N}, 2'b11);
    chk("R1 lock high", busLockN, 1);
    chk("R1 no ack", holdAck, 0);
    chk("R1 data off", busDataOe, 0);
    chk("R1 no response", rspValid, 0);
    chk("R1 drivers on", busAddrOe, 1);
    chk("R1 ready", reqReady, 1);

    doCycle(3'd3, 24'h123456, 2'b11, 16'h0000, 1'b0, 0, 16'hBEEF, 1'b0);
    doCycle(3'd4, 24'hABCDE0, 2'b10, 16'h5A00, 1'b0, 2, 16'h0000, 1'b0);
    doCycle(3'd5, 24'hFF0042, 2'b01, 16'h0000, 1'b0, 1, 16'h00C3, 1'b0);
    doCycle(3'd6, 24'h771234, 2'b11, 16'hA55A, 1'b0, 0, 16'h0000, 1'b0);
    doCycle(3'd7, 24'h0FFFFE, 2'b11, 16'h0000, 1'b0, 3, 16'h9090, 1'b0);
    doCycle(3'd0, 24'h000000, 2'b11, 16'h0000, 1'b0, 1, 16'h0008, 1'b0);
    doCycle(3'd1, 24'h000000, 2'b00, 16'h0000, 1'b0, 0, 16'h0000, 1'b0);
    doCycle(3'd2, 24'h000003, 2'b01, 16'h0000, 1'b0, 0, 16'h0000, 1'b0);

    // hold raised alongside a request: grant must wait for the boundary
    doCycle(3'd4, 24'h004444, 2'b11, 16'h1234, 1'b0, 3, 16'h0000, 1'b1);
    waitGrant();
    // R10: ready and requests during hold
    busReadyN = 1'b0; busDataIn = 16'hDEAD;
    reqValid = 1'b1; reqKind = 3'd3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no response in hold", rspValid, 0);
      chk("R10 no accept in hold", reqReady, 0);
    end
    reqValid = 1'b0; busReadyN = 1'b1;
    releaseHold();
    doCycle(3'd3, 24'h000100, 2'b11, 16'h0000, 1'b0, 1, 16'h7E7E, 1'b0);

    // locked pair blocks the grant
    doCycle(3'd3, 24'h000200, 2'b11, 16'h0000, 1'b1, 0, 16'h1111, 1'b0);
    chk("R12 lock held between", busLockN, 0);
    holdReq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12 no grant while locked", holdAck, 0);
      chk("R12 requests accepted", reqReady, 1);
    end
    doCycle(3'd4, 24'h000200, 2'b11, 16'h2222, 1'b0, 0, 16'h0000, 1'b0);
    chk("R12 lock released", busLockN, 1);
    waitGrant();
    releaseHold();

    repeat (3) @(negedge clk);
    chk("R3 all responses seen", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule